// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a small processor core that finishes one instruction in each clock cycle. It runs eight instructions of a 32-bit load/store instruction set. Five are register-to-register operations: add, subtract, AND, OR and signed set-on-less-than. The other three are load word, store word and branch-if-equal. The core holds its own program counter, a 32-entry register file, an ALU, a decoder for the main control lines and a second decoder that refines the ALU function. It also has a separate adder for PC+4, a branch-target adder and the operand and write-back multiplexers. Instruction storage and data storage are two separate word arrays, so fetch and data access never compete for one resource.

The ALU function is chosen in two steps. The main decoder turns the opcode into a 2-bit operation class. That class means add for memory addressing or subtract for branch compare. For register-format words only, the class is refined by the function field. A branch is taken only when the decoded branch line is high and the ALU reports a zero result.

Both arrays are filled through a word-wide load port, usually while reset is held. Execution is observed on the register write-back bus, the data-store bus and the program counter, all brought out as outputs.

Top module: `sc_core`

## Requirements
- R1: Reset is synchronous and active low. While `rst_n` is low at a rising edge, the PC becomes 0 and every register reads back 0 afterwards. While `rst_n` is low, `rf_we_o` and `dm_we_o` stay low.
- R2: The opcode is instruction bits [31:26]. The codes are 000000 register format, 100011 load, 101011 store and 000100 branch-equal. Any other opcode is a no-operation: no register write, no data write, and the PC advances by 4.
- R3: Register format takes rs from bits [25:21], rt from [20:16], rd from [15:11], a shift field from [10:6] and funct from [5:0]. The result of rs op rt is written to rd for these funct codes: 100000 add, 100010 subtract, 100100 AND, 100101 OR, 101010 set-on-less-than. Any other funct, or a nonzero shift field, writes nothing.
- R4: Set-on-less-than writes 1 when rs < rt as signed two's-complement values, and 0 otherwise.
- R5: Load computes the byte address rs + sign-extended bits [15:0]. It writes the data word at that address into register rt.
- R6: Store writes register rt to the data word at rs + sign-extended bits [15:0] and writes no register. `dm_addr_o` and `dm_wdata_o` show the byte address and the data.
- R7: Branch-equal sets the next PC to PC+4 + (sign-extended offset << 2) when rs equals rt, and to PC+4 otherwise. Negative offsets branch backwards.
- R8: Every instruction other than a taken branch advances the PC by 4 at the next rising edge.
- R9: Register 0 always reads as 0. A write addressed to it is shown on the write-back bus but has no effect.
- R10: Register and data-memory writes take effect at the rising edge that ends the instruction, so the next instruction already reads the new value.
- R11: With `prog_we` high at a rising edge, `prog_data` is written to word `prog_addr`. The target is instruction storage when `prog_sel` is 0 and data storage when it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_we | input | 1 | Load-port write strobe |
| prog_sel | input | 1 | Load-port target: 0 instruction words, 1 data words |
| prog_addr | input | 6 | Load-port word index |
| prog_data | input | 32 | Load-port word value |
| pc_o | output | 32 | Current program counter (byte address) |
| rf_we_o | output | 1 | Register write enable of the current instruction |
| rf_waddr_o | output | 5 | Destination register number |
| rf_wdata_o | output | 32 | Value written back to the register file |
| dm_we_o | output | 1 | Data-store enable of the current instruction |
| dm_addr_o | output | 32 | Data byte address from the ALU |
| dm_wdata_o | output | 32 | Data word being stored |

## Verification
One straight-line program runs through every opcode and funct code. Loaded operands mix signs, so the add and subtract results and the signed comparison in both directions tell a correct signed compare from an unsigned one, and an add from a subtract. The program also includes:
- a store followed at once by a load of the same word, which proves the write took effect at the edge;
- a write to register 0 and then a read of it;
- a negative load offset;
- a branch pair with unequal and with equal operands, where a taken forward branch skips two words that would have left visible writes;
- an unknown opcode and an unknown funct, each of which must stay silent;
- a backward branch that holds the PC in place.

A reset in the middle of the run then replaces the first instruction with one that reads two registers, which shows that reset cleared the register file.

// File: rtl/sc_pkg.sv
// Package sc_pkg
// Shared encodings and the control bundle of the single-cycle core.
// Assumes a fixed 32-bit word and 5-bit register numbers.
package sc_pkg;

    localparam int XLEN   = 32;
    localparam int NREG   = 32;
    localparam int RAW    = 5;

    localparam logic [5:0] OPC_RTYPE = 6'b000000;
    localparam logic [5:0] OPC_LOAD  = 6'b100011;
    localparam logic [5:0] OPC_STORE = 6'b101011;
    localparam logic [5:0] OPC_BEQ   = 6'b000100;

    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_AND = 6'b100100;
    localparam logic [5:0] FN_OR  = 6'b100101;
    localparam logic [5:0] FN_SLT = 6'b101010;

    // Operation class passed from the main decoder to the ALU decoder
    typedef enum logic [1:0] {
        CLS_MEM   = 2'b00,
        CLS_CMP   = 2'b01,
        CLS_FUNCT = 2'b10
    } op_class_e;

    // ALU function select
    typedef enum logic [2:0] {
        FU_AND = 3'b000,
        FU_OR  = 3'b001,
        FU_ADD = 3'b010,
        FU_SUB = 3'b110,
        FU_SLT = 3'b111
    } alu_fn_e;

    // Control lines produced from the opcode alone
    typedef struct packed {
        logic      dst_is_rd;
        logic      b_is_imm;
        logic      wb_from_mem;
        logic      reg_wr;
        logic      mem_rd;
        logic      mem_wr;
        logic      is_branch;
        op_class_e op_class;
    } ctl_t;

endpackage

// File: rtl/sc_main_dec.sv
// Module sc_main_dec
// Turns the 6-bit opcode into the datapath control lines.
// Assumes unknown opcodes must produce no write of any kind.
module sc_main_dec
    import sc_pkg::*;
(
    input  logic [5:0] opcode,
    output ctl_t       ctl
);

    // Opcode to control-line table
    always_comb begin
        ctl = '{dst_is_rd: 1'b0, b_is_imm: 1'b0, wb_from_mem: 1'b0,
                reg_wr: 1'b0, mem_rd: 1'b0, mem_wr: 1'b0,
                is_branch: 1'b0, op_class: CLS_MEM};
        case (opcode)
            OPC_RTYPE: begin
                ctl.dst_is_rd = 1'b1;
                ctl.reg_wr    = 1'b1;
                ctl.op_class  = CLS_FUNCT;
            end
            OPC_LOAD: begin
                ctl.b_is_imm    = 1'b1;
                ctl.wb_from_mem = 1'b1;
                ctl.reg_wr      = 1'b1;
                ctl.mem_rd      = 1'b1;
            end
            OPC_STORE: begin
                ctl.b_is_imm = 1'b1;
                ctl.mem_wr   = 1'b1;
            end
            OPC_BEQ: begin
                ctl.is_branch = 1'b1;
                ctl.op_class  = CLS_CMP;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sc_alu_dec.sv
// Module sc_alu_dec
// Second decode level: picks the ALU function from the operation class,
// and from funct and the shift field for register-format words.
// fn_ok drops low for register-format words that are not supported.
module sc_alu_dec
    import sc_pkg::*;
(
    input  op_class_e  op_class,
    input  logic [5:0] funct,
    input  logic [4:0] shamt,
    output alu_fn_e    fn,
    output logic       fn_ok
);

    // Class and funct to ALU function
    always_comb begin
        fn    = FU_ADD;
        fn_ok = 1'b1;
        case (op_class)
            CLS_MEM: fn = FU_ADD;
            CLS_CMP: fn = FU_SUB;
            CLS_FUNCT: begin
                case (funct)
                    FN_ADD:  fn = FU_ADD;
                    FN_SUB:  fn = FU_SUB;
                    FN_AND:  fn = FU_AND;
                    FN_OR:   fn = FU_OR;
                    FN_SLT:  fn = FU_SLT;
                    default: fn_ok = 1'b0;
                endcase
                if (shamt != 5'd0) fn_ok = 1'b0;
            end
            default: fn_ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/sc_alu.sv
// Module sc_alu
// Combinational ALU with a zero flag; the comparison is signed.
module sc_alu
    import sc_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_fn_e      fn,
    output logic [W-1:0] y,
    output logic         zero
);

    // Function select
    always_comb begin
        case (fn)
            FU_AND:  y = a & b;
            FU_OR:   y = a | b;
            FU_ADD:  y = a + b;
            FU_SUB:  y = a - b;
            FU_SLT:  y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = a + b;
        endcase
    end

    // Zero flag used by branch-equal
    always_comb zero = (y == '0);

endmodule

// File: rtl/sc_regfile.sv
// Module sc_regfile
// Two combinational read ports and one write port that takes effect at the
// rising edge. Entry 0 has no storage and reads as zero. Reset clears all
// entries.
module sc_regfile #(
    parameter int W    = 32,
    parameter int NENT = 32,
    localparam int AW  = $clog2(NENT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2
);

    logic [W-1:0] mem_q [1:NENT-1];

    // Write port with synchronous clear
    always_ff @(posedge clk) begin
        for (int i = 1; i < NENT; i++) begin
            if (!rst_n)
                mem_q[i] <= '0;
            else if (we && wa == AW'(i))
                mem_q[i] <= wd;
        end
    end

    // Read ports; address 0 falls through to zero
    always_comb begin
        rd1 = '0;
        rd2 = '0;
        for (int i = 1; i < NENT; i++) begin
            if (ra1 == AW'(i)) rd1 = mem_q[i];
            if (ra2 == AW'(i)) rd2 = mem_q[i];
        end
    end

    AST_RF_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wa != '0) |=> (mem_q[$past(wa)] == $past(wd))); // R10

endmodule

// File: rtl/sc_core.sv
// Module sc_core
// Single-cycle core: fetch, decode, register read, ALU, data access and
// write-back all happen within one clock. Instruction and data words are
// internal arrays filled through the load port. Assumes word-aligned accesses;
// the low two address bits are ignored.
module sc_core
    import sc_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    localparam int IAW = $clog2(IMEM_WORDS),
    localparam int DAW = $clog2(DMEM_WORDS),
    localparam int PAW = (IAW > DAW) ? IAW : DAW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prog_we,
    input  logic             prog_sel,
    input  logic [PAW-1:0]   prog_addr,
    input  logic [XLEN-1:0]  prog_data,
    output logic [XLEN-1:0]  pc_o,
    output logic             rf_we_o,
    output logic [RAW-1:0]   rf_waddr_o,
    output logic [XLEN-1:0]  rf_wdata_o,
    output logic             dm_we_o,
    output logic [XLEN-1:0]  dm_addr_o,
    output logic [XLEN-1:0]  dm_wdata_o
);

    logic [XLEN-1:0] pc_q, pc_next, pc_plus4, br_target;
    logic [XLEN-1:0] instr, imm_ext;
    logic [XLEN-1:0] imem_q [IMEM_WORDS];
    logic [XLEN-1:0] dmem_q [DMEM_WORDS];
    logic [XLEN-1:0] rd1, rd2, alu_b, alu_y, mem_rdata, wb_data;
    logic [RAW-1:0]  f_rs, f_rt, f_rd, f_shamt;
    logic [5:0]      f_op, f_funct;
    logic            alu_zero, fn_ok, take_br, rf_we, dm_we;
    ctl_t            ctl;
    alu_fn_e         alu_fn;

    // Instruction fetch and field split
    always_comb begin
        instr   = imem_q[pc_q[IAW+1:2]];
        f_op    = instr[31:26];
        f_rs    = instr[25:21];
        f_rt    = instr[20:16];
        f_rd    = instr[15:11];
        f_shamt = instr[10:6];
        f_funct = instr[5:0];
        imm_ext = {{16{instr[15]}}, instr[15:0]};
    end

    sc_main_dec u_main_dec (
        .opcode (f_op),
        .ctl    (ctl)
    );

    sc_alu_dec u_alu_dec (
        .op_class (ctl.op_class),
        .funct    (f_funct),
        .shamt    (f_shamt),
        .fn       (alu_fn),
        .fn_ok    (fn_ok)
    );

    sc_regfile #(.W(XLEN), .NENT(NREG)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .ra1   (f_rs),
        .ra2   (f_rt),
        .we    (rf_we),
        .wa    (rf_waddr_o),
        .wd    (wb_data),
        .rd1   (rd1),
        .rd2   (rd2)
    );

    // Second ALU operand: register or sign-extended offset
    always_comb alu_b = ctl.b_is_imm ? imm_ext : rd2;

    sc_alu #(.W(XLEN)) u_alu (
        .a    (rd1),
        .b    (alu_b),
        .fn   (alu_fn),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // Data read and write-back selection
    always_comb begin
        mem_rdata = ctl.mem_rd ? dmem_q[alu_y[DAW+1:2]] : '0;
        wb_data   = ctl.wb_from_mem ? mem_rdata : alu_y;
    end

    // Write enables, gated by reset and funct validity
    always_comb begin
        rf_we = rst_n & ctl.reg_wr & fn_ok;
        dm_we = rst_n & ctl.mem_wr;
    end

    // Next-PC: dedicated increment adder and branch-target adder
    always_comb begin
        pc_plus4  = pc_q + 32'd4;
        br_target = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
        take_br   = ctl.is_branch & alu_zero;
        pc_next   = take_br ? br_target : pc_plus4;
    end

    // Program counter register
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_next;
    end

    // Instruction storage, written only through the load port
    always_ff @(posedge clk) begin
        if (prog_we && !prog_sel) imem_q[IAW'(prog_addr)] <= prog_data;
    end

    // Data storage: load port first, then the store path
    always_ff @(posedge clk) begin
        if (prog_we && prog_sel)
            dmem_q[DAW'(prog_addr)] <= prog_data;
        else if (dm_we)
            dmem_q[alu_y[DAW+1:2]] <= rd2;
    end

    // Observation outputs
    always_comb begin
        pc_o       = pc_q;
        rf_we_o    = rf_we;
        rf_waddr_o = ctl.dst_is_rd ? f_rd : f_rt;
        rf_wdata_o = wb_data;
        dm_we_o    = dm_we;
        dm_addr_o  = alu_y;
        dm_wdata_o = rd2;
    end

    AST_PC_RESET: assert property (@(posedge clk)
        !rst_n |=> (pc_q == '0)); // R1
    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl.is_branch |=> (pc_q == $past(pc_q) + 32'd4)); // R8
    AST_BRANCH_NEEDS_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_next != pc_plus4) |-> (rd1 == rd2)); // R7
    AST_STORE_NO_REGWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        dm_we_o |-> !rf_we_o); // R6
    AST_UNKNOWN_OP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (f_op != OPC_RTYPE && f_op != OPC_LOAD && f_op != OPC_STORE && f_op != OPC_BEQ)
        |-> (!rf_we_o && !dm_we_o)); // R2

endmodule

// File: tb/sc_core_tb.sv
`timescale 1ns/1ps
// Bench for sc_core: one program walked against an expected-result table,
// then a directed mid-run reset.
module sc_core_tb_top;

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
        return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    localparam int NSTEP = 21;

    localparam logic [31:0] PROG [NSTEP] = '{
        enc_i(6'b100011, 0, 1, 16'd0),          // lw r1,0(r0)
        enc_i(6'b100011, 0, 2, 16'd4),          // lw r2,4(r0)
        enc_i(6'b100011, 0, 3, 16'd8),          // lw r3,8(r0)
        enc_r(1, 2, 4, 6'b100000),              // add r4
        enc_r(1, 2, 5, 6'b100010),              // sub r5
        enc_r(3, 2, 6, 6'b100100),              // and r6
        enc_r(1, 2, 7, 6'b100101),              // or r7
        enc_r(2, 1, 8, 6'b101010),              // slt r8 (-3<5)
        enc_r(1, 2, 9, 6'b101010),              // slt r9 (5<-3)
        enc_i(6'b101011, 0, 5, 16'd16),         // sw r5,16(r0)
        enc_i(6'b100011, 0, 10, 16'd16),        // lw r10,16(r0)
        enc_r(1, 1, 0, 6'b100000),              // add r0,r1,r1
        enc_r(0, 1, 11, 6'b100000),             // add r11,r0,r1
        enc_i(6'b000100, 1, 2, 16'd5),          // beq unequal
        enc_i(6'b000100, 10, 5, 16'd2),         // beq equal, to 68
        enc_r(1, 1, 12, 6'b100000),             // skipped
        enc_r(1, 1, 12, 6'b100000),             // skipped
        enc_i(6'b001000, 0, 13, 16'd1),         // unknown opcode
        enc_i(6'b100011, 10, 13, 16'hFFF8),     // lw r13,-8(r10)
        enc_r(1, 2, 14, 6'b100110),             // unknown funct
        enc_i(6'b000100, 0, 0, 16'hFFFF)        // beq r0,r0,-1
    };

    typedef struct packed {
        logic [31:0] pc;
        logic        rwe;
        logic [4:0]  wa;
        logic [31:0] wd;
        logic        mwe;
        logic [31:0] ma;
        logic [31:0] md;
        logic [3:0]  req;
    } exp_t;

    localparam exp_t VEC [NSTEP] = '{
        '{32'd0,  1'b1, 5'd1,  32'd5,        1'b0, 32'd0,  32'd0, 4'd5},  // R5
        '{32'd4,  1'b1, 5'd2,  32'hFFFFFFFD, 1'b0, 32'd0,  32'd0, 4'd5},  // R5
        '{32'd8,  1'b1, 5'd3,  32'h0F0F00FF, 1'b0, 32'd0,  32'd0, 4'd5},  // R5
        '{32'd12, 1'b1, 5'd4,  32'd2,        1'b0, 32'd0,  32'd0, 4'd3},  // R3
        '{32'd16, 1'b1, 5'd5,  32'd8,        1'b0, 32'd0,  32'd0, 4'd3},  // R3
        '{32'd20, 1'b1, 5'd6,  32'h0F0F00FD, 1'b0, 32'd0,  32'd0, 4'd3},  // R3
        '{32'd24, 1'b1, 5'd7,  32'hFFFFFFFD, 1'b0, 32'd0,  32'd0, 4'd3},  // R3
        '{32'd28, 1'b1, 5'd8,  32'd1,        1'b0, 32'd0,  32'd0, 4'd4},  // R4
        '{32'd32, 1'b1, 5'd9,  32'd0,        1'b0, 32'd0,  32'd0, 4'd4},  // R4
        '{32'd36, 1'b0, 5'd0,  32'd0,        1'b1, 32'd16, 32'd8, 4'd6},  // R6
        '{32'd40, 1'b1, 5'd10, 32'd8,        1'b0, 32'd0,  32'd0, 4'd10}, // R10
        '{32'd44, 1'b1, 5'd0,  32'd10,       1'b0, 32'd0,  32'd0, 4'd9},  // R9
        '{32'd48, 1'b1, 5'd11, 32'd5,        1'b0, 32'd0,  32'd0, 4'd9},  // R9
        '{32'd52, 1'b0, 5'd0,  32'd0,        1'b0, 32'd0,  32'd0, 4'd7},  // R7
        '{32'd56, 1'b0, 5'd0,  32'd0,        1'b0, 32'd0,  32'd0, 4'd8},  // R8
        '{32'd68, 1'b0, 5'd0,  32'd0,        1'b0, 32'd0,  32'd0, 4'd7},  // R7
        '{32'd72, 1'b1, 5'd13, 32'd5,        1'b0, 32'd0,  32'd0, 4'd2},  // R2
        '{32'd76, 1'b0, 5'd0,  32'd0,        1'b0, 32'd0,  32'd0, 4'd3},  // R3
        '{32'd80, 1'b0, 5'd0,  32'd0,        1'b0, 32'd0,  32'd0, 4'd8},  // R8
        '{32'd80, 1'b0, 5'd0,  32'd0,        1'b0, 32'd0,  32'd0, 4'd7},  // R7
        '{32'd80, 1'b0, 5'd0,  32'd0,        1'b0, 32'd0,  32'd0, 4'd7}   // R7
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prog_we = 1'b0;
    logic        prog_sel = 1'b0;
    logic [5:0]  prog_addr = '0;
    logic [31:0] prog_data = '0;
    logic [31:0] pc_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
    logic [4:0]  rf_waddr_o;
    logic        rf_we_o, dm_we_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sc_core dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .prog_we    (prog_we),
        .prog_sel   (prog_sel),
        .prog_addr  (prog_addr),
        .prog_data  (prog_data),
        .pc_o       (pc_o),
        .rf_we_o    (rf_we_o),
        .rf_waddr_o (rf_waddr_o),
        .rf_wdata_o (rf_wdata_o),
        .dm_we_o    (dm_we_o),
        .dm_addr_o  (dm_addr_o),
        .dm_wdata_o (dm_wdata_o)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic load_word(logic sel, int addr, logic [31:0] data);
        @(negedge clk);
        prog_we   = 1'b1;
        prog_sel  = sel;
        prog_addr = 6'(addr);
        prog_data = data;
        @(negedge clk);
        prog_we   = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<=5000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // Load through the port while reset is held (R11)
        for (int i = 0; i < 64; i++) load_word(1'b0, i, 32'd0);
        for (int i = 0; i < NSTEP; i++) load_word(1'b0, i, PROG[i]);
        load_word(1'b1, 0, 32'd5);
        load_word(1'b1, 1, 32'hFFFFFFFD);
        load_word(1'b1, 2, 32'h0F0F00FF);

        // R1: reset state, with a load word sitting at address 0
        #1;
        chk("R1", "pc in reset", pc_o, 32'd0);
        chk("R1", "rf_we in reset", 32'(rf_we_o), 32'd0);
        chk("R1", "dm_we in reset", 32'(dm_we_o), 32'd0);

        @(negedge clk);
        rst_n = 1'b1;
        for (int s = 0; s < NSTEP; s++) begin
            if (s != 0) @(negedge clk);
            #1;
            begin
                string rq;
                rq = $sformatf("R%0d", VEC[s].req);
                chk(rq, $sformatf("step %0d pc", s), pc_o, VEC[s].pc);
                chk(rq, $sformatf("step %0d rf_we", s), 32'(rf_we_o), 32'(VEC[s].rwe));
                if (VEC[s].rwe) begin
                    chk(rq, $sformatf("step %0d waddr", s), 32'(rf_waddr_o), 32'(VEC[s].wa));
                    chk(rq, $sformatf("step %0d wdata", s), rf_wdata_o, VEC[s].wd);
                end
                chk(rq, $sformatf("step %0d dm_we", s), 32'(dm_we_o), 32'(VEC[s].mwe));
                if (VEC[s].mwe) begin
                    chk(rq, $sformatf("step %0d dm_addr", s), dm_addr_o, VEC[s].ma);
                    chk(rq, $sformatf("step %0d dm_wdata", s), dm_wdata_o, VEC[s].md);
                end
            end
        end

        // R1: mid-run reset, write enables drop at once and the PC clears at the edge
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R1", "rf_we low during reset", 32'(rf_we_o), 32'd0);
        chk("R1", "pc before reset edge", pc_o, 32'd80);
        @(negedge clk);
        #1;
        chk("R1", "pc after reset edge", pc_o, 32'd0);
        // Replace word 0 with add r4,r1,r2 to read the cleared registers
        load_word(1'b0, 0, enc_r(1, 2, 4, 6'b100000));
        rst_n = 1'b1;
        #1;
        chk("R1", "cleared regs add waddr", 32'(rf_waddr_o), 32'd4);
        chk("R1", "cleared regs add wdata", rf_wdata_o, 32'd0);
        @(negedge clk);
        #1;
        chk("R8", "pc after first step", pc_o, 32'd4);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule